// File: doc/BRIEF.md
# Write strobe qualifier with glitch filter and power-up lockout

This block sits at the pin boundary of a byte-wide nonvolatile memory. It takes the active-low chip-enable, write-enable and output-enable pins, which are asynchronous to the core, and samples them on a fast core clock. From them it produces one clean, single-cycle write event. The event carries the address that was on the bus when the combined strobe became active and the data that was on the bus when the strobe was first released.

A write strobe is the interval in which chip-enable and write-enable are both low. The later of the two falling edges opens it and the earlier of the two rising edges closes it. The block drops a strobe if it is shorter than a programmable number of clock samples, if output-enable is low at any sample inside it, or if writes are locked out. Writes are locked out while the digital supply-good input is low, and for a programmable number of clocks after it returns high. Command decoding and analog supply sensing are handled elsewhere.

Top module: `wr_strobe_qual`

## Requirements
- R1: Each accepted strobe produces exactly one `wr_valid` pulse. The pulse is one clock wide and appears a few clocks after the strobe is released, because the pins first pass through two-flop synchronisers.
- R2: `wr_addr` of an accepted write is the value of `addr_in` at the first sample in which chip-enable and write-enable are both low. This holds whichever pin fell later, and later address changes during the strobe have no effect.
- R3: `wr_data` of an accepted write is the value of `data_in` at the first sample after the strobe in which either chip-enable or write-enable is high again.
- R4: A strobe is accepted only if it lasts at least `MIN_LOW` consecutive clock samples. A strobe of `MIN_LOW`-1 samples or fewer produces no pulse.
- R5: If `oe_n` is low at any sample within the strobe, no write is produced.
- R6: Write-enable low while chip-enable is high, or chip-enable low while write-enable is high, produces no write, however long it lasts.
- R7: After reset with `supply_ok` high, writes stay locked out until `LOCK_CYC` clocks have passed since the synchronised supply-good went high.
- R8: While `supply_ok` is low no write is produced. A drop of `supply_ok` restarts the full lockout interval.
- R9: Reset clears `wr_valid`, `wr_addr` and `wr_data` to zero. `wr_addr` and `wr_data` keep the last accepted write until the next one, and a rejected strobe leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_ok | input | 1 | Supply above sense threshold |
| ce_n | input | 1 | Chip enable pin, active low |
| we_n | input | 1 | Write enable pin, active low |
| oe_n | input | 1 | Output enable pin, active low |
| addr_in | input | AW | Address bus |
| data_in | input | DW | Data bus |
| wr_valid | output | 1 | One-clock write event |
| wr_addr | output | AW | Address of the last accepted write |
| wr_data | output | DW | Data of the last accepted write |

## Verification
The hardest situation to reach is a strobe whose two edges come from different pins while the bus changes around them. The address must be taken at the later fall and the data at the earlier rise. Directed stimulus leads with one pin for several clocks while the bus holds a decoy address, then opens the strobe with the other pin and changes the address inside it. It also sets the final data exactly in the release sample and replaces it one clock later. Randomised strobes around the `MIN_LOW` boundary, some with output-enable dropped mid-strobe, are mixed with a supply drop that forces the lockout to restart.

// File: rtl/wr_strobe_qual.sv
module wr_strobe_qual #(
  parameter int AW       = 18,
  parameter int DW       = 8,
  parameter int MIN_LOW  = 4,
  parameter int LOCK_CYC = 2500000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          supply_ok,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  localparam int LW = $clog2(MIN_LOW + 1);
  localparam int KW = $clog2(LOCK_CYC + 1);

  logic [1:0]    ce_sy, we_sy, oe_sy, sup_sy;
  logic [AW-1:0] a_p1, a_p2, addr_lat;
  logic [DW-1:0] d_p1, d_p2;
  logic          act_q, ok;
  logic [LW-1:0] low_cnt;
  logic [KW-1:0] lock_cnt;

  wire act      = ~ce_sy[1] & ~we_sy[1];
  wire start    = act & ~act_q;
  wire rel      = ~act & act_q;
  wire unlocked = (lock_cnt == KW'(LOCK_CYC));
  wire accept   = rel & ok & (low_cnt == LW'(MIN_LOW));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_sy  <= 2'b11;
      we_sy  <= 2'b11;
      oe_sy  <= 2'b11;
      sup_sy <= 2'b00;
      a_p1   <= '0;
      a_p2   <= '0;
      d_p1   <= '0;
      d_p2   <= '0;
    end else begin
      ce_sy  <= {ce_sy[0], ce_n};
      we_sy  <= {we_sy[0], we_n};
      oe_sy  <= {oe_sy[0], oe_n};
      sup_sy <= {sup_sy[0], supply_ok};
      a_p1   <= addr_in;
      a_p2   <= a_p1;
      d_p1   <= data_in;
      d_p2   <= d_p1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          lock_cnt <= '0;
    else if (!sup_sy[1])                 lock_cnt <= '0;
    else if (!unlocked)                  lock_cnt <= lock_cnt + KW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q    <= 1'b0;
      low_cnt  <= '0;
      ok       <= 1'b0;
      addr_lat <= '0;
    end else begin
      act_q <= act;
      if (!act)                               low_cnt <= '0;
      else if (low_cnt != LW'(MIN_LOW))       low_cnt <= low_cnt + LW'(1);
      if (start) begin
        ok       <= oe_sy[1] & unlocked;
        addr_lat <= a_p2;
      end else if (act) begin
        ok <= ok & oe_sy[1] & unlocked;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_valid <= accept;
      if (accept) begin
        wr_addr <= addr_lat;
        wr_data <= d_p2;
      end
    end
  end
endmodule

// File: rtl/wr_strobe_qual_chk.sv
module wr_strobe_qual_chk #(
  parameter int AW       = 18,
  parameter int DW       = 8,
  parameter int MIN_LOW  = 4,
  parameter int LOCK_CYC = 2500000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          supply_ok,
  input logic          ce_n,
  input logic          we_n,
  input logic          oe_n,
  input logic          wr_valid,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data
);
  localparam int LW = $clog2(MIN_LOW + 1);
  localparam int KW = $clog2(LOCK_CYC + 1);

  logic [LW-1:0] run, last_run;
  logic          bad, last_bad;
  logic [KW-1:0] sup_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= '0; last_run <= '0; bad <= 1'b0; last_bad <= 1'b0;
    end else if (!ce_n && !we_n) begin
      if (run != LW'(MIN_LOW)) run <= run + LW'(1);
      bad <= bad | ~oe_n;
    end else if (run != '0) begin
      last_run <= run;
      last_bad <= bad;
      run      <= '0;
      bad      <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          sup_cnt <= '0;
    else if (!supply_ok)                 sup_cnt <= '0;
    else if (sup_cnt != KW'(LOCK_CYC))   sup_cnt <= sup_cnt + KW'(1);
  end

  p_single_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);
  // covers R4 and R6: the run only counts samples with both pins low
  p_min_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> last_run == LW'(MIN_LOW));
  p_oe_inhibit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !last_bad);
  p_lockout_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> sup_cnt == KW'(LOCK_CYC));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |-> $stable(wr_addr) && $stable(wr_data));
endmodule

bind wr_strobe_qual wr_strobe_qual_chk #(
  .AW(AW), .DW(DW), .MIN_LOW(MIN_LOW), .LOCK_CYC(LOCK_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .ce_n(ce_n), .we_n(we_n),
  .oe_n(oe_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/test_wr_strobe_qual.sv
`timescale 1ns/1ps
module test_wr_strobe_qual;
  localparam int AW = 18, DW = 8, MIN_LOW = 4, LOCK_CYC = 300;

  logic clk = 0, rst_n = 0, supply_ok = 1, ce_n = 1, we_n = 1, oe_n = 1;
  logic [AW-1:0] addr_in = '0;
  logic [DW-1:0] data_in = '0;
  logic wr_valid;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  int checks = 0, fails = 0, ev_cnt = 0;
  logic [AW-1:0] ev_addr;
  logic [DW-1:0] ev_data;
  logic [AW-1:0] last_a = '0;
  logic [DW-1:0] last_d = '0;
  bit done = 0;

  always #2 clk = ~clk;

  wr_strobe_qual #(.AW(AW), .DW(DW), .MIN_LOW(MIN_LOW), .LOCK_CYC(LOCK_CYC)) i_wr_strobe_qual (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr_in(addr_in), .data_in(data_in), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data));

  always @(negedge clk) if (rst_n && wr_valid) begin
    ev_cnt  = ev_cnt + 1;
    ev_addr = wr_addr;
    ev_data = wr_data;
  end

  function automatic bit exp_ok(int len, bit oe_lo, bit unl);
    return unl && !oe_lo && len >= MIN_LOW;
  endfunction

  task automatic check(bit c, string tag, longint act, longint exp);
    checks++;
    if (!c) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // lead: clocks one pin is low before the strobe opens; lead_ce picks that pin
  task automatic strobe(int lead, bit lead_ce, logic [AW-1:0] a_first, logic [AW-1:0] a_fall,
                        logic [AW-1:0] a_later, int len, bit oe_lo, logic [DW-1:0] d_fin);
    @(negedge clk);
    ev_cnt = 0;
    ce_n = 1; we_n = 1; oe_n = 1;
    if (lead > 0) begin
      addr_in = a_first;
      if (lead_ce) ce_n = 0; else we_n = 0;
      wait_cyc(lead);
    end
    addr_in = a_fall; ce_n = 0; we_n = 0; data_in = ~d_fin;
    for (int i = 1; i < len; i++) begin
      @(negedge clk);
      if (i == 1) begin addr_in = a_later; if (oe_lo) oe_n = 0; end
    end
    @(negedge clk);
    if (lead_ce) we_n = 1; else ce_n = 1;
    data_in = d_fin;
    @(negedge clk);
    data_in = d_fin ^ 8'h5a; ce_n = 1; we_n = 1; oe_n = 1; addr_in = a_later ^ 18'h3;
    wait_cyc(8);
  endtask

  task automatic expect_write(bit exp, logic [AW-1:0] a, logic [DW-1:0] d, string tag);
    check(ev_cnt == (exp ? 1 : 0), {tag, " pulse count"}, ev_cnt, exp ? 1 : 0);
    if (exp) begin
      check(ev_addr == a, {tag, " addr"}, ev_addr, a);
      check(ev_data == d, {tag, " data"}, ev_data, d);
      last_a = a; last_d = d;
    end else begin
      check(wr_addr == last_a, {tag, " addr held"}, wr_addr, last_a);
      check(wr_data == last_d, {tag, " data held"}, wr_data, last_d);
    end
  endtask

  initial begin
    wait_cyc(5);
    check(wr_valid == 0 && wr_addr == 0 && wr_data == 0, "R9 reset state", wr_addr, 0);
    rst_n = 1;
    strobe(0, 0, 0, 18'h00111, 18'h00111, 6, 0, 8'h11);
    expect_write(0, 0, 0, "R7 locked after power-up");
    wait_cyc(LOCK_CYC + 20);
    strobe(0, 0, 0, 18'h12345, 18'h12345, 6, 0, 8'hA5);
    expect_write(1, 18'h12345, 8'hA5, "R1 R7 write after lockout");
    strobe(0, 0, 0, 18'h00abc, 18'h00abc, MIN_LOW - 1, 0, 8'h3C);
    expect_write(0, 0, 0, "R4 one sample short");
    strobe(0, 0, 0, 18'h00abd, 18'h00abd, MIN_LOW, 0, 8'h3D);
    expect_write(1, 18'h00abd, 8'h3D, "R4 exactly minimum");
    strobe(0, 0, 0, 18'h00abe, 18'h00abe, 1, 0, 8'h3E);
    expect_write(0, 0, 0, "R4 single sample glitch");
    strobe(3, 0, 18'h3ffff, 18'h2aaaa, 18'h15555, 6, 0, 8'hC3);
    expect_write(1, 18'h2aaaa, 8'hC3, "R2 R3 WE first, CE falls later");
    strobe(4, 1, 18'h01010, 18'h20202, 18'h30303, 5, 0, 8'h7E);
    expect_write(1, 18'h20202, 8'h7E, "R2 R3 CE first, WE falls later");
    strobe(0, 0, 0, 18'h00777, 18'h00777, 8, 1, 8'h77);
    expect_write(0, 0, 0, "R5 OE low inside strobe");
    @(negedge clk); ev_cnt = 0; ce_n = 1; we_n = 0; addr_in = 18'h1; wait_cyc(10); we_n = 1; wait_cyc(8);
    expect_write(0, 0, 0, "R6 WE alone");
    @(negedge clk); ev_cnt = 0; we_n = 1; ce_n = 0; wait_cyc(10); ce_n = 1; wait_cyc(8);
    expect_write(0, 0, 0, "R6 CE alone");
    supply_ok = 0;
    strobe(0, 0, 0, 18'h00444, 18'h00444, 8, 0, 8'h44);
    expect_write(0, 0, 0, "R8 supply low");
    supply_ok = 1;
    strobe(0, 0, 0, 18'h00445, 18'h00445, 8, 0, 8'h45);
    expect_write(0, 0, 0, "R8 lockout restarted");
    wait_cyc(LOCK_CYC + 20);
    strobe(0, 0, 0, 18'h00446, 18'h00446, 8, 0, 8'h46);
    expect_write(1, 18'h00446, 8'h46, "R8 write after restart");
    begin
      int seed = 17;
      void'($urandom(seed));
      for (int k = 0; k < 60; k++) begin
        int len = 1 + int'($urandom_range(MIN_LOW + 2));
        bit oe_lo = (len >= 2) && ($urandom_range(3) == 0);
        bit lce = $urandom_range(1) == 1;
        int lead = int'($urandom_range(3));
        logic [AW-1:0] af = AW'($urandom);
        logic [DW-1:0] df = DW'($urandom);
        strobe(lead, lce, AW'($urandom), af, AW'($urandom), len, oe_lo, df);
        expect_write(exp_ok(len, oe_lo, 1), af, df, "R1 R2 R3 R4 R5 random");
      end
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule